// File: doc/BRIEF.md
# Dual-Channel UART Sleep Controller

This block governs low-power sleep for a two-channel UART. It watches the per-channel status of the transmit FIFO, the transmit shift register, the receive FIFO and the pending interrupts. It also watches the raw serial receive lines and the modem-control inputs of both channels. From these it drives one clock-enable output that gates the UART core clock and the baud-rate clock. The controller itself runs on a free-running clock that is never gated, so it can see wake-up activity while the rest of the UART is stopped.

Sleep needs permission at two levels: a global enhanced-features bit, and a sleep-enable bit on each channel. When both levels allow it and both channels have been quiet for a qualifying interval, the controller stops the clocks. It restarts them when any of these events occurs:
- a start bit arrives on either receive line;
- a byte is pushed into either transmit FIFO;
- any modem input moves away from the value it had when sleep began;
- software withdraws permission.

After such a wake, the controller waits until the work is done and then goes back to sleep. Software does not need to act. The controller also keeps a sticky error flag that is set if a divisor-latch write strobe arrives while the clocks are stopped.

Top module: `usc_sleep_ctrl`

## Requirements
- R1: Sleep is entered only while `feat_en` is 1 and every bit of `ch_sleep_en` is 1.
- R2: Sleep is entered only when each channel has all of the following: TX FIFO empty, TX shift register empty, RX FIFO empty, no interrupt pending, synchronized receive line high, modem inputs unchanged from the previous cycle, and no `tx_push` strobe.
- R3: `core_clk_en` is 0 while `asleep` is 1 and no wake condition is present. `core_clk_en` is 1 at all other times.
- R4: A high-to-low transition on either `rx_line` bit, after the two-flop synchronizer, is a wake event. `core_clk_en` is 1 in the cycle after the second rising clock edge following the line falling. `asleep` clears on the next edge.
- R5: A `tx_push` strobe on either channel while asleep sets `core_clk_en` to 1 in the same cycle and clears `asleep` at the next edge.
- R6: `modem_in` is captured when sleep is entered. While asleep, any synchronized modem bit that differs from its captured value is a wake event; channel c owns bits [4c+3:4c].
- R7: After any wake, the block re-enters sleep by itself once the entry conditions of R1 and R2 hold again.
- R8: Clearing any bit of `ch_sleep_en`, or `feat_en`, while asleep sets `core_clk_en` to 1 in the same cycle, and the block stays awake while that bit is 0.
- R9: A `div_wr` strobe sampled while `asleep` is 1 sets `div_wr_err`. The flag stays set until reset. A `div_wr` strobe while awake leaves the flag at 0.
- R10: After the clocks are enabled, the entry conditions must hold at REARM_CYCLES (default 2) consecutive rising edges before `asleep` goes to 1. A single quiet cycle followed by activity does not enter sleep.
- R11: During and right after reset, `core_clk_en` is 1, `asleep` is 0 and `div_wr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Global enhanced-features enable |
| ch_sleep_en | input | NCH | Per-channel sleep enable |
| txf_empty | input | NCH | Transmit FIFO empty, per channel |
| txs_empty | input | NCH | Transmit shift register empty, per channel |
| rxf_empty | input | NCH | Receive FIFO empty, per channel |
| irq_pend | input | NCH | Interrupt pending, per channel |
| rx_line | input | NCH | Asynchronous serial receive lines |
| modem_in | input | NCH*MDM_W | Asynchronous modem-control inputs, MDM_W per channel |
| tx_push | input | NCH | Strobe: byte written into a transmit FIFO |
| div_wr | input | 1 | Strobe: divisor-latch write |
| core_clk_en | output | 1 | Enable for the UART core and baud clocks |
| asleep | output | 1 | Registered sleep state |
| div_wr_err | output | 1 | Sticky error: divisor written while asleep |

## Verification
The assertions check several rules on every cycle:
- each entry into sleep was preceded by permission (R1), full idleness on both channels (R2) and a quiet previous cycle (R10);
- a transmit push, a start edge, a modem change or a withdrawn permission while asleep always ends sleep at the next edge;
- the divisor error flag sets on a write during sleep and never clears on its own.

Only the bench scenarios can show the rest:
- the exact wake latency through the synchronizers;
- that each single blocking condition keeps the block awake;
- that sleep returns by itself once a transmission drains or a modem line settles at its new level;
- that reset clears the sticky flag.

// File: rtl/usc_pkg.sv
package usc_pkg;

  typedef enum logic {
    PWR_RUN   = 1'b0,
    PWR_SLEEP = 1'b1
  } pwr_state_t;

  // One channel is quiet when nothing is queued, pending or moving on it.
  function automatic logic chan_quiet(
    input logic txf_e,
    input logic txs_e,
    input logic rxf_e,
    input logic irq,
    input logic rx_hi,
    input logic mdm_still
  );
    return txf_e & txs_e & rxf_e & ~irq & rx_hi & mdm_still;
  endfunction

  // High-to-low transition between two successive samples.
  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/usc_sync.sv
module usc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end

endmodule

// File: rtl/usc_wake_det.sv
module usc_wake_det
  import usc_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int MDM_W = 4,
  localparam int MW   = NCH * MDM_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rx_s,
  input  logic [MW-1:0]  mdm_s,
  input  logic [NCH-1:0] tx_push,
  input  logic           capture,
  input  logic           sleeping,
  output logic           start_evt,
  output logic           mdm_evt,
  output logic           push_evt,
  output logic [NCH-1:0] mdm_still
);

  logic [NCH-1:0] rx_prev;
  logic [MW-1:0]  mdm_prev;
  logic [MW-1:0]  mdm_cap;
  logic [NCH-1:0] start_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev  <= '1;
      mdm_prev <= '0;
      mdm_cap  <= '0;
    end else begin
      rx_prev  <= rx_s;
      mdm_prev <= mdm_s;
      if (capture) mdm_cap <= mdm_s;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign start_ch[c]  = fell(rx_prev[c], rx_s[c]);
    assign mdm_still[c] = (mdm_s[c*MDM_W +: MDM_W] == mdm_prev[c*MDM_W +: MDM_W]);
  end

  assign start_evt = |start_ch;
  assign mdm_evt   = sleeping & (mdm_s != mdm_cap);
  assign push_evt  = |tx_push;

endmodule

// File: rtl/usc_entry_qual.sv
module usc_entry_qual #(
  parameter int REARM_CYCLES = 2,
  localparam int CW          = $clog2(REARM_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic quiet,
  output logic enter
);

  logic [CW-1:0] run_cnt;
  logic          cnt_full;

  assign cnt_full = (run_cnt == CW'(REARM_CYCLES - 1));
  assign enter    = armed & quiet & cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (!armed || !quiet) run_cnt <= '0;
    else if (!cnt_full)        run_cnt <= run_cnt + 1'b1;
  end

  if (REARM_CYCLES > 1) begin : g_hold_chk
    assert_rearm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      enter |-> $past(quiet) && $past(armed));
  end

endmodule

// File: rtl/usc_sleep_ctrl.sv
module usc_sleep_ctrl
  import usc_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int MDM_W        = 4,
  parameter int REARM_CYCLES = 2,
  localparam int MW          = NCH * MDM_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           feat_en,
  input  logic [NCH-1:0] ch_sleep_en,
  input  logic [NCH-1:0] txf_empty,
  input  logic [NCH-1:0] txs_empty,
  input  logic [NCH-1:0] rxf_empty,
  input  logic [NCH-1:0] irq_pend,
  input  logic [NCH-1:0] rx_line,
  input  logic [MW-1:0]  modem_in,
  input  logic [NCH-1:0] tx_push,
  input  logic           div_wr,
  output logic           core_clk_en,
  output logic           asleep,
  output logic           div_wr_err
);

  pwr_state_t     state_q;
  logic [NCH-1:0] rx_s;
  logic [MW-1:0]  mdm_s;
  logic [NCH-1:0] mdm_still;
  logic [NCH-1:0] chan_ok;
  logic           sleep_allowed;
  logic           quiet_now;
  logic           enter_sleep;
  logic           start_evt, mdm_evt, push_evt;
  logic           wake_now;
  logic           sleeping;

  usc_sync #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_line), .q_sync(rx_s));

  usc_sync #(.W(MW), .RST_VAL({MW{1'b0}})) u_mdm_sync (
    .clk(clk), .rst_n(rst_n), .d_async(modem_in), .q_sync(mdm_s));

  usc_wake_det #(.NCH(NCH), .MDM_W(MDM_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .mdm_s(mdm_s), .tx_push(tx_push),
    .capture(enter_sleep), .sleeping(sleeping), .start_evt(start_evt),
    .mdm_evt(mdm_evt), .push_evt(push_evt), .mdm_still(mdm_still));

  for (genvar c = 0; c < NCH; c++) begin : g_quiet
    assign chan_ok[c] = chan_quiet(txf_empty[c], txs_empty[c], rxf_empty[c],
                                   irq_pend[c], rx_s[c], mdm_still[c]);
  end

  assign sleeping      = (state_q == PWR_SLEEP);
  assign sleep_allowed = feat_en & (&ch_sleep_en);
  assign quiet_now     = sleep_allowed & (&chan_ok) & ~push_evt;
  assign wake_now      = sleeping & (start_evt | mdm_evt | push_evt | ~sleep_allowed);

  usc_entry_qual #(.REARM_CYCLES(REARM_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .armed(~sleeping), .quiet(quiet_now),
    .enter(enter_sleep));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_RUN;
    end else begin
      unique case (state_q)
        PWR_RUN:   if (enter_sleep) state_q <= PWR_SLEEP;
        PWR_SLEEP: if (wake_now)    state_q <= PWR_RUN;
        default:   state_q <= PWR_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_wr_err <= 1'b0;
    else if (div_wr && sleeping) div_wr_err <= 1'b1;
  end

  assign core_clk_en = ~sleeping | wake_now;
  assign asleep      = sleeping;

  assert_entry_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(feat_en) && $past(&ch_sleep_en));

  assert_entry_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(&txf_empty) && $past(&txs_empty) && $past(&rxf_empty)
                      && !$past(|irq_pend) && !$past(|tx_push));

  assert_start_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && start_evt) |=> !asleep);

  assert_push_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && |tx_push) |=> !asleep);

  assert_modem_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && mdm_evt) |=> !asleep);

  assert_disable_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(feat_en && &ch_sleep_en) |=> !asleep);

  assert_div_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && div_wr) |=> div_wr_err);

  assert_div_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr_err |=> div_wr_err);

endmodule

// File: tb/sim_usc_sleep_ctrl.sv
module sim_usc_sleep_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int MDM_W = 4;
  localparam int NVEC = 8;

  // Vector layout: [13] feat, [12:11] ch_en, [10:9] txf_empty, [8:7] txs_empty,
  // [6:5] rxf_empty, [4:3] irq, [2:1] rx_line, [0] expect asleep.
  localparam logic [13:0] VEC [NVEC] = '{
    14'b1_11_11_11_11_00_11_1,
    14'b0_11_11_11_11_00_11_0,
    14'b1_01_11_11_11_00_11_0,
    14'b1_11_10_11_11_00_11_0,
    14'b1_11_11_01_11_00_11_0,
    14'b1_11_11_11_10_00_11_0,
    14'b1_11_11_11_11_10_11_0,
    14'b1_11_11_11_11_00_10_0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic feat_en;
  logic [NCH-1:0] ch_sleep_en, txf_empty, txs_empty, rxf_empty, irq_pend, rx_line, tx_push;
  logic [NCH*MDM_W-1:0] modem_in;
  logic div_wr;
  logic core_clk_en, asleep, div_wr_err;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usc_sleep_ctrl #(.NCH(NCH), .MDM_W(MDM_W), .REARM_CYCLES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .ch_sleep_en(ch_sleep_en),
    .txf_empty(txf_empty), .txs_empty(txs_empty), .rxf_empty(rxf_empty),
    .irq_pend(irq_pend), .rx_line(rx_line), .modem_in(modem_in),
    .tx_push(tx_push), .div_wr(div_wr), .core_clk_en(core_clk_en),
    .asleep(asleep), .div_wr_err(div_wr_err));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    feat_en = 1'b1; ch_sleep_en = '1; txf_empty = '1; txs_empty = '1;
    rxf_empty = '1; irq_pend = '0; rx_line = '1; tx_push = '0; div_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    modem_in = '0;
    ch_sleep_en = '0;
    rst_n = 1'b0;
    step(3);
    chk("R11", "clk_en in reset", core_clk_en, 1'b1);
    chk("R11", "asleep in reset", asleep, 1'b0);
    chk("R11", "div_err in reset", div_wr_err, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R11", "clk_en after reset", core_clk_en, 1'b1);

    // Table: R1 permission gating, R2 per-condition blocking
    for (int i = 0; i < NVEC; i++) begin
      idle_inputs(); ch_sleep_en = '0; irq_pend = '1;
      step(4);
      feat_en     = VEC[i][13];
      ch_sleep_en = VEC[i][12:11];
      txf_empty   = VEC[i][10:9];
      txs_empty   = VEC[i][8:7];
      rxf_empty   = VEC[i][6:5];
      irq_pend    = VEC[i][4:3];
      rx_line     = VEC[i][2:1];
      step(6);
      chk(i < 3 ? "R1" : "R2", $sformatf("vec %0d asleep", i), asleep, VEC[i][0]);
      chk("R3", $sformatf("vec %0d clk_en", i), core_clk_en, ~VEC[i][0]);
    end

    // R10: one quiet cycle then activity must not enter sleep
    idle_inputs(); irq_pend = 2'b11;
    step(3);
    div_wr = 1'b1; step(1); div_wr = 1'b0;
    chk("R9", "div write while awake", div_wr_err, 1'b0);
    irq_pend = 2'b00; step(1);
    irq_pend = 2'b01; step(1);
    chk("R10", "single quiet cycle", asleep, 1'b0);
    irq_pend = 2'b00; step(1);
    chk("R10", "one cycle into hold", asleep, 1'b0);
    step(1);
    chk("R10", "after two quiet cycles", asleep, 1'b1);
    chk("R3", "clk_en while asleep", core_clk_en, 1'b0);

    // R9: divisor write during sleep
    div_wr = 1'b1; step(1); div_wr = 1'b0;
    chk("R9", "div write while asleep", div_wr_err, 1'b1);

    // R4: start bit on channel 1
    rx_line = 2'b01; step(1);
    chk("R4", "clk_en one edge after fall", core_clk_en, 1'b0);
    step(1);
    chk("R4", "clk_en two edges after fall", core_clk_en, 1'b1);
    step(1);
    chk("R4", "asleep cleared", asleep, 1'b0);
    rx_line = 2'b11; step(8);
    chk("R7", "re-sleep after rx idle", asleep, 1'b1);

    // R5: transmit push on channel 0
    tx_push = 2'b01; txf_empty = 2'b10; #1;
    chk("R5", "clk_en same cycle as push", core_clk_en, 1'b1);
    step(1); tx_push = 2'b00;
    chk("R5", "asleep cleared by push", asleep, 1'b0);
    step(5);
    chk("R2", "awake while tx fifo holds data", asleep, 1'b0);
    txf_empty = 2'b11; txs_empty = 2'b10; step(5);
    chk("R2", "awake while shifting", asleep, 1'b0);
    txs_empty = 2'b11; step(4);
    chk("R7", "re-sleep after last char", asleep, 1'b1);
    chk("R9", "div_err still set", div_wr_err, 1'b1);

    // R6: modem change on channel 1, bit 1 (modem_in[5])
    modem_in[5] = 1'b1; step(1);
    chk("R6", "clk_en one edge after change", core_clk_en, 1'b0);
    step(1);
    chk("R6", "clk_en two edges after change", core_clk_en, 1'b1);
    step(1);
    chk("R6", "asleep cleared by modem", asleep, 1'b0);
    step(6);
    chk("R7", "re-sleep at new modem level", asleep, 1'b1);
    modem_in[5] = 1'b0; step(2);
    chk("R6", "change back vs capture wakes", core_clk_en, 1'b1);
    step(6);
    chk("R7", "re-sleep again", asleep, 1'b1);

    // R8: withdraw a channel enable
    ch_sleep_en = 2'b10; #1;
    chk("R8", "clk_en same cycle as disable", core_clk_en, 1'b1);
    step(1);
    chk("R8", "asleep cleared by disable", asleep, 1'b0);
    step(6);
    chk("R8", "stays awake while disabled", asleep, 1'b0);
    chk("R8", "clk_en while disabled", core_clk_en, 1'b1);
    ch_sleep_en = 2'b11; step(6);
    chk("R7", "sleep after re-enable", asleep, 1'b1);

    // R9/R11: reset clears sticky flag
    rst_n = 1'b0; step(1);
    chk("R9", "reset clears div_err", div_wr_err, 1'b0);
    chk("R11", "clk_en in second reset", core_clk_en, 1'b1);
    rst_n = 1'b1; step(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule